// File: doc/BRIEF.md
# Folded-Table Sine/Cosine Oscillator

This block is a numerically controlled oscillator. A phase accumulator adds a programmable increment on every clock in which the enable is high. The upper bits of the accumulator form a truncated phase. From that phase the block produces a pair of signed quadrature samples, one sine and one cosine, in two's complement.

The lookup table covers only one eighth of a cycle. It is filled at elaboration time from the width parameters, so no memory-image file is needed. Each table word holds the sine and cosine magnitudes of the same small angle. The top three phase bits pick the octant. In odd octants the address is mirrored. The octant also decides which field feeds which output and which sign each output takes. The octant controls are delayed by one stage so that they match the synchronous table read.

The increment sets the output frequency as f_clk·inc/2^ACC_W. With the enable low, the oscillator freezes on its current sample.

Top module: `nco_sincos`

## Requirements
- R1: When `rst` is high at a clock edge, the accumulator becomes zero and both outputs become zero after that edge. After a reset held for at least two edges, the first edge with `rst` low shows the sample for phase zero.
- R2: At each edge with `rst` low and `en` high, the accumulator becomes (accumulator + `phase_inc`) modulo 2^ACC_W.
- R3: At each edge with `en` low and `rst` low, the accumulator keeps its value. From the third such edge onward, both outputs stay constant.
- R4: The lookup phase p is accumulator bits [ACC_W-1 : ACC_W-PHA_W]. A sample stands for the angle 2π(p+½)/2^PHA_W.
- R5: `sin_out` is within one LSB of round(M·sin(angle)), where M = 2^(AMP_W-1)-1. The most negative code never appears.
- R6: `cos_out` is within one LSB of round(M·cos(angle)). The most negative code never appears.
- R7: The sine magnitude at phase p is exactly equal to the cosine magnitude at phase 2^(PHA_W-2)-1-p, for every p in the first quadrant.
- R8: `sin_out` is negative exactly when phase bit PHA_W-1 is set. `cos_out` is negative exactly when phase bits PHA_W-1 and PHA_W-2 differ.
- R9: The outputs after edge n show the sample for the accumulator value held after edge n-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the phase when high |
| phase_inc | input | ACC_W | Phase step added per enabled clock |
| sin_out | output | AMP_W | Registered signed sine sample |
| cos_out | output | AMP_W | Registered signed cosine sample |

## Verification
A unit phase step walks every truncated phase exactly once, so all eight octants and every mirror point are visited. Two faults show up here:
- A design that mirrors the address in the wrong octants, or swaps the wrong field, produces a jump at each octant boundary.
- A design with a sign taken from the wrong phase bit produces a wrong sign in whole quadrants.

A negative step wraps the accumulator backwards. A large odd step spreads samples across the whole cycle. A control delay that is off by one stage would pair a magnitude with the octant of the neighbouring sample. Enable gaps and a reset in the middle of a run expose any stage that keeps moving when it should hold or clear.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Per-sample steering decoded from the three octant bits.
  typedef struct packed {
    logic swap;     // sine takes the cosine field, cosine the sine field
    logic sin_neg;  // negate the sine output
    logic cos_neg;  // negate the cosine output
  } fold_ctl_t;

  function automatic fold_ctl_t ctl_of_octant(input logic [2:0] oct);
    fold_ctl_t c;
    c.swap    = oct[0] ^ oct[1];
    c.sin_neg = oct[2];
    c.cos_neg = oct[2] ^ oct[1];
    return c;
  endfunction

  // Round a unit-range value to an integer magnitude of full scale.
  function automatic int unsigned quant_mag(input real v, input int unsigned full);
    real x;
    x = v * real'(full) + 0.5;
    return $rtoi(x);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + inc;
  end

endmodule

// File: rtl/nco_octant_rom.sv
module nco_octant_rom #(
  parameter int AW = 10,
  parameter int MW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [MW-1:0] sin_mag_q,
  output logic [MW-1:0] cos_mag_q
);

  localparam int          DEPTH = 1 << AW;
  localparam int unsigned FULL  = (1 << MW) - 1;
  localparam real         PI    = 3.14159265358979323846;

  // Word g holds {cos, sin} magnitudes of the angle (g + 1/2) * (pi/4) / DEPTH.
  logic [2*MW-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam real TH = (real'(g) + 0.5) * PI / (4.0 * real'(DEPTH));
    assign table_w[g] = {MW'(nco_pkg::quant_mag($cos(TH), FULL)),
                         MW'(nco_pkg::quant_mag($sin(TH), FULL))};
  end

  always_ff @(posedge clk) begin
    sin_mag_q <= table_w[addr][MW-1:0];
    cos_mag_q <= table_w[addr][2*MW-1:MW];
  end

endmodule

// File: rtl/nco_fold_out.sv
module nco_fold_out #(
  parameter int MW = 11,
  localparam int OW = MW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  nco_pkg::fold_ctl_t  ctl,
  input  logic [MW-1:0]       sin_mag,
  input  logic [MW-1:0]       cos_mag,
  output logic [OW-1:0]       sin_q,
  output logic [OW-1:0]       cos_q
);

  logic [MW-1:0] s_pick, c_pick;
  logic [OW-1:0] s_ext, c_ext;

  assign s_pick = ctl.swap ? cos_mag : sin_mag;
  assign c_pick = ctl.swap ? sin_mag : cos_mag;
  assign s_ext  = {1'b0, s_pick};
  assign c_ext  = {1'b0, c_pick};

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= ctl.sin_neg ? -s_ext : s_ext;
      cos_q <= ctl.cos_neg ? -c_ext : c_ext;
    end
  end

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int ACC_W = 18,
  parameter int PHA_W = 13,
  parameter int AMP_W = 12,
  localparam int AW   = PHA_W - 3,
  localparam int MW   = AMP_W - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        phase_inc,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] cos_out
);

  logic [ACC_W-1:0]   acc_q;
  logic [PHA_W-1:0]   phase;
  logic [2:0]         octant;
  logic [AW-1:0]      low_bits;
  logic [AW-1:0]      rom_addr;
  nco_pkg::fold_ctl_t ctl_now, ctl_q;
  logic [MW-1:0]      sin_mag, cos_mag;
  logic [AMP_W-1:0]   sin_w, cos_w;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .inc(phase_inc), .acc_q(acc_q)
  );

  assign phase    = acc_q[ACC_W-1 -: PHA_W];
  assign octant   = phase[PHA_W-1 -: 3];
  assign low_bits = phase[AW-1:0];
  assign rom_addr = octant[0] ? ~low_bits : low_bits;
  assign ctl_now  = nco_pkg::ctl_of_octant(octant);

  nco_octant_rom #(.AW(AW), .MW(MW)) u_rom (
    .clk(clk), .addr(rom_addr), .sin_mag_q(sin_mag), .cos_mag_q(cos_mag)
  );

  // Steering bits follow the table read by one stage.
  always_ff @(posedge clk) ctl_q <= ctl_now;

  nco_fold_out #(.MW(MW)) u_fold (
    .clk(clk), .rst(rst), .ctl(ctl_q),
    .sin_mag(sin_mag), .cos_mag(cos_mag),
    .sin_q(sin_w), .cos_q(cos_w)
  );

  assign sin_out = sin_w;
  assign cos_out = cos_w;

endmodule

// File: rtl/nco_sincos_chk.sv
module nco_sincos_chk #(
  parameter int ACC_W = 18,
  parameter int AMP_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        phase_inc,
  input logic [ACC_W-1:0]        acc_q,
  input logic signed [AMP_W-1:0] sin_out,
  input logic signed [AMP_W-1:0] cos_out
);

  localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> acc_q == ACC_W'($past(acc_q) + $past(phase_inc)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> acc_q == $past(acc_q));

  assert_sin_range_R5: assert property (@(posedge clk) disable iff (rst)
    sin_out != MOST_NEG);

  assert_cos_range_R6: assert property (@(posedge clk) disable iff (rst)
    cos_out != MOST_NEG);

  assert_sin_sign_R8: assert property (@(posedge clk) disable iff (rst)
    sin_out != 0 |-> sin_out[AMP_W-1] == $past(acc_q[ACC_W-1], 2));

  assert_cos_sign_R8: assert property (@(posedge clk) disable iff (rst)
    cos_out != 0 |-> cos_out[AMP_W-1] == $past(acc_q[ACC_W-1] ^ acc_q[ACC_W-2], 2));

endmodule

bind nco_sincos nco_sincos_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .phase_inc(phase_inc),
  .acc_q(acc_q), .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/sim_nco_sincos.sv
`timescale 1ns/1ps
module sim_nco_sincos;
  localparam int ACC_W = 18;
  localparam int PHA_W = 13;
  localparam int AMP_W = 12;
  localparam int NPH   = 1 << PHA_W;
  localparam int QTR   = NPH / 4;
  localparam int FULL  = (1 << (AMP_W - 1)) - 1;
  localparam int SHIFT = ACC_W - PHA_W;
  localparam longint MASK = (64'd1 << ACC_W) - 1;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [ACC_W-1:0] inc = '0;
  logic signed [AMP_W-1:0] sin_o, cos_o;

  always #2 clk = ~clk;

  nco_sincos #(.ACC_W(ACC_W), .PHA_W(PHA_W), .AMP_W(AMP_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .phase_inc(inc),
    .sin_out(sin_o), .cos_out(cos_o)
  );

  typedef struct {
    bit zero;
    int ph;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  longint acc_m  = 0;   // model value after the previous edge
  longint acc_m2 = 0;   // model value two edges back
  int sin_cap [NPH];
  int cos_cap [NPH];
  bit cap_ok  [NPH];

  function automatic int ref_val(input int ph, input bit want_cos);
    real phi, v, a;
    int  m;
    phi = 2.0 * PI * (real'(ph) + 0.5) / real'(NPH);
    v   = want_cos ? $cos(phi) : $sin(phi);
    a   = (v < 0.0) ? -v : v;
    m   = $rtoi(a * real'(FULL) + 0.5);
    return (v < 0.0) ? -m : m;
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic note(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected output for that edge.
  task automatic step(input bit r, input bit e, input longint d);
    exp_t it;
    @(negedge clk);
    rst = r;
    en  = e;
    inc = d[ACC_W-1:0];
    @(posedge clk);
    it.zero = r;
    it.ph   = int'(acc_m2 >> SHIFT);
    acc_m2  = acc_m;
    if (r)      acc_m = 0;
    else if (e) acc_m = (acc_m + d) & MASK;
    sb.push_back(it);
  endtask

  // Monitor: compare the registered outputs half a cycle after each edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      int es, ec;
      it = sb.pop_front();
      if (it.zero) begin
        note(sin_o == 0, "R1 sine cleared", int'(sin_o), 0);
        note(cos_o == 0, "R1 cosine cleared", int'(cos_o), 0);
      end else begin
        es = ref_val(it.ph, 1'b0);
        ec = ref_val(it.ph, 1'b1);
        note(iabs(int'(sin_o) - es) <= 1, "R4/R5/R9 sine value", int'(sin_o), es);
        note(iabs(int'(cos_o) - ec) <= 1, "R4/R6/R9 cosine value", int'(cos_o), ec);
        note((sin_o < 0) == (es < 0), "R8 sine sign", int'(sin_o), es);
        note((cos_o < 0) == (ec < 0), "R8 cosine sign", int'(cos_o), ec);
        sin_cap[it.ph] = int'(sin_o);
        cos_cap[it.ph] = int'(cos_o);
        cap_ok[it.ph]  = 1'b1;
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int held_s, held_c;
    for (int i = 0; i < NPH; i++) cap_ok[i] = 1'b0;

    // R1: reset state, with the increment applied but ignored
    for (int i = 0; i < 4; i++) step(1, 1, 64'd777);

    // R1/R9: released with enable low, phase zero appears at once
    for (int i = 0; i < 3; i++) step(0, 0, 64'd0);

    // R2/R4: unit phase step walks every truncated phase through all octants
    for (int i = 0; i < NPH + 2; i++) step(0, 1, 64'd1 << SHIFT);

    // R2: negative step wraps the accumulator backwards through zero
    for (int i = 0; i < 300; i++) step(0, 1, MASK - (64'd3 << SHIFT) + 1);

    // R2: large odd step with sub-phase carries
    for (int i = 0; i < 600; i++) step(0, 1, 64'h0A5A5);

    // R3: enable gaps, alternating and long
    for (int i = 0; i < 200; i++) step(0, i[0], 64'h13579);
    for (int i = 0; i < 3; i++) step(0, 0, 64'h3FFFF);
    @(negedge clk);
    held_s = int'(sin_o);
    held_c = int'(cos_o);
    for (int i = 0; i < 5; i++) step(0, 0, 64'h2AAAA);
    @(negedge clk);
    note(int'(sin_o) == held_s, "R3 sine held", int'(sin_o), held_s);
    note(int'(cos_o) == held_c, "R3 cosine held", int'(cos_o), held_c);

    // R1: reset in mid-run, then resume from phase zero
    for (int i = 0; i < 3; i++) step(1, 1, 64'h01234);
    for (int i = 0; i < 40; i++) step(0, 1, 64'h01234);
    for (int i = 0; i < 3; i++) step(0, 0, 64'd0);
    @(negedge clk);
    @(negedge clk);

    // R7: exact mirror symmetry between sine and cosine in the first quadrant
    for (int p = 0; p < QTR; p++) begin
      if (!cap_ok[p] || !cap_ok[QTR - 1 - p]) begin
        note(1'b0, "R7 phase not captured", p, QTR - 1 - p);
      end else begin
        note(iabs(sin_cap[p]) == iabs(cos_cap[QTR - 1 - p]), "R7 mirror magnitude",
             iabs(sin_cap[p]), iabs(cos_cap[QTR - 1 - p]));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule